// File: doc/BRIEF.md
# Token-Chained Front-End Readout Sequencer

This block sequences the readout of a group of front-end chips that share one output data bus. Each chip has its own controller. A start pulse sends every controller through an acquisition phase and then a conversion phase, each of fixed length. After that the controllers take turns on the shared bus. Turns pass down the chain with a token, from chip 0 upwards. A chip drives its buffered events one word per clock. It then hands the token to its neighbour and drops into a low-power idle state. A chip with no events hands the token on at once.

The top level holds all the controllers, the logic that merges the shared bus, the pulse that gives chip 0 its token, and a done flag. The done flag rises once the last chip in the chain has given up the token. Another start pulse re-arms every controller, even in the middle of a run. The conversion itself is modelled only by its length in cycles. Each event word carries the sending chip's index and the event's position within that chip's buffer.

Top module: `rdo_chain`

## Requirements
- R1: A start sampled at a clock edge puts every chip into acquisition for ACQ_CYC cycles and then conversion for CONV_CYC cycles. Chip 0's first word is on the bus ACQ_CYC+CONV_CYC+1 cycles after that edge, and nothing is driven on the bus earlier.
- R2: At most one bit of bus_oe_o is high in any cycle, and bus_data_o is zero whenever no bit of bus_oe_o is high.
- R3: Chips send in ascending index order, and chip i starts only after chip i-1 has finished. A chip with n events sends n words on n consecutive cycles. Each word holds the chip index in its upper IW bits and the event index 0..n-1 in its lower CW bits.
- R4: tok_o[i] is high for exactly one cycle, and that cycle directly follows chip i's last word.
- R5: A chip whose event count is zero never drives the bus. It raises tok_o[i] in the cycle after its token arrives.
- R6: Each chip latches its event count from its CW-bit slice of evt_cnt_i (chip i at bits i*CW upward) at the end of acquisition. Changes to evt_cnt_i during conversion or readout have no effect on the words sent.
- R7: lp_o[i] is high while chip i is idle or waiting for the token. It is low during acquisition, conversion, sending, and the token-pass cycle.
- R8: done_o rises in the cycle after the last chip's tok_o pulse and stays high until the next start. A start clears it in the following cycle.
- R9: A start sampled in any state aborts the run in progress. From the next cycle no chip drives the bus and all chips are back in acquisition.
- R10: During reset, bus_oe_o, tok_o and done_o are low, bus_data_o is zero and lp_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new acquisition cycle for all chips |
| evt_cnt_i | input | NCHIP*CW | Per-chip buffered event count, chip i at bits [i*CW +: CW] |
| bus_data_o | output | IW+CW | Shared data bus |
| bus_oe_o | output | NCHIP | Per-chip bus drive enable |
| tok_o | output | NCHIP | Per-chip token output pulse |
| lp_o | output | NCHIP | Per-chip low-power state indicator |
| done_o | output | 1 | Whole chain has finished readout |

## Verification
The hardest case to reach is a start that arrives while a chip is in the middle of sending. The abort must clear the bus, the token and the done flag together, and the next run must still follow the normal timing. The stimulus runs a cycle with several events per chip, raises start at a computed cycle inside chip 0's burst, and then checks the following run cycle by cycle. Changing the event counts during conversion checks that the count was latched, and a chain with only zero-count chips checks the fast token pass.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_CONV = 3'd2,
    ST_WAIT = 3'd3,
    ST_SEND = 3'd4,
    ST_PASS = 3'd5
  } rdo_st_e;
endpackage

// File: rtl/rdo_node.sv
module rdo_node
  import rdo_pkg::*;
#(
  parameter int ACQ_CYC = 6,
  parameter int CONV_CYC = 4,
  parameter int CW = 4,
  parameter int IW = 2,
  parameter int CHIP_ID = 0,
  localparam int MAXPH = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC,
  localparam int PW = $clog2(MAXPH + 1),
  localparam int DW = IW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tok_i,
  input  logic [CW-1:0] evt_cnt_i,
  output logic          conv_end_o,
  output logic          tok_o,
  output logic          oe_o,
  output logic [DW-1:0] word_o,
  output logic          lp_o
);

  rdo_st_e       state_q, state_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [CW-1:0] n_q, n_d;
  logic [CW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    n_d     = n_q;
    idx_d   = idx_q;
    if (start_i) begin
      state_d = ST_ACQ;
      ph_d    = '0;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_ACQ: begin
          if (ph_q == PW'(ACQ_CYC - 1)) begin
            state_d = ST_CONV;
            ph_d    = '0;
            n_d     = evt_cnt_i;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (ph_q == PW'(CONV_CYC - 1)) begin
            state_d = ST_WAIT;
            ph_d    = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (tok_i) begin
            idx_d   = '0;
            state_d = (n_q == '0) ? ST_PASS : ST_SEND;
          end
        end
        ST_SEND: begin
          if (idx_q == n_q - 1'b1) state_d = ST_PASS;
          else                     idx_d   = idx_q + 1'b1;
        end
        ST_PASS: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      n_q     <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      n_q     <= n_d;
      idx_q   <= idx_d;
    end
  end

  assign conv_end_o = (state_q == ST_CONV) && (ph_q == PW'(CONV_CYC - 1)) && !start_i;
  assign tok_o      = (state_q == ST_PASS);
  assign oe_o       = (state_q == ST_SEND);
  assign word_o     = oe_o ? {IW'(CHIP_ID), idx_q} : '0;
  assign lp_o       = (state_q == ST_IDLE) || (state_q == ST_WAIT);

  p_acq_to_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && ph_q == PW'(ACQ_CYC - 1) && !start_i) |=> (state_q == ST_CONV));

  p_tok_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |=> !tok_o);

  p_zero_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && tok_i && n_q == '0 && !start_i) |=> (tok_o && !oe_o));

  p_send_not_lp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> !lp_o);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_ACQ && !oe_o));

endmodule

// File: rtl/rdo_bus_or.sv
module rdo_bus_or #(
  parameter int NCHIP = 4,
  parameter int DW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCHIP-1:0]    oe_i,
  input  logic [NCHIP*DW-1:0] words_i,
  output logic [DW-1:0]       data_o
);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NCHIP; i++) data_o = data_o | words_i[i*DW +: DW];
  end

  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_i));

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_i == '0) |-> (data_o == '0));

endmodule

// File: rtl/rdo_chain.sv
module rdo_chain #(
  parameter int NCHIP = 4,
  parameter int ACQ_CYC = 6,
  parameter int CONV_CYC = 4,
  parameter int CW = 4,
  localparam int IW = (NCHIP > 1) ? $clog2(NCHIP) : 1,
  localparam int DW = IW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NCHIP*CW-1:0] evt_cnt_i,
  output logic [DW-1:0]       bus_data_o,
  output logic [NCHIP-1:0]    bus_oe_o,
  output logic [NCHIP-1:0]    tok_o,
  output logic [NCHIP-1:0]    lp_o,
  output logic                done_o
);

  logic [NCHIP-1:0]    tok_in;
  logic [NCHIP-1:0]    conv_end;
  logic [NCHIP*DW-1:0] words;
  logic                kick_q, kick_d;
  logic                done_q, done_d;

  assign tok_in[0] = kick_q;

  for (genvar g = 0; g < NCHIP; g++) begin : g_node
    if (g > 0) begin : g_link
      assign tok_in[g] = tok_o[g-1];
    end
    rdo_node #(
      .ACQ_CYC (ACQ_CYC),
      .CONV_CYC(CONV_CYC),
      .CW      (CW),
      .IW      (IW),
      .CHIP_ID (g)
    ) u_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .tok_i     (tok_in[g]),
      .evt_cnt_i (evt_cnt_i[g*CW +: CW]),
      .conv_end_o(conv_end[g]),
      .tok_o     (tok_o[g]),
      .oe_o      (bus_oe_o[g]),
      .word_o    (words[g*DW +: DW]),
      .lp_o      (lp_o[g])
    );
  end

  rdo_bus_or #(.NCHIP(NCHIP), .DW(DW)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_i   (bus_oe_o),
    .words_i(words),
    .data_o (bus_data_o)
  );

  always_comb begin
    kick_d = conv_end[0] && !start_i;
    if (start_i)                done_d = 1'b0;
    else if (tok_o[NCHIP-1])    done_d = 1'b1;
    else                        done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      kick_q <= kick_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tok_o[NCHIP-1]));

  p_start_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

endmodule

// File: tb/rdo_chain_tb.sv
`timescale 1ns/1ps
module rdo_chain_tb;
  localparam int NCH = 4;
  localparam int A = 6;
  localparam int C = 4;
  localparam int CW = 4;
  localparam int IW = 2;
  localparam int DW = IW + CW;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [NCH*CW-1:0] evt_cnt_i;
  logic [DW-1:0]     bus_data_o;
  logic [NCH-1:0]    bus_oe_o;
  logic [NCH-1:0]    tok_o;
  logic [NCH-1:0]    lp_o;
  logic              done_o;

  int n_chk;
  int n_bad;
  bit reported;

  rdo_chain #(.NCHIP(NCH), .ACQ_CYC(A), .CONV_CYC(C), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .evt_cnt_i(evt_cnt_i),
    .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o), .tok_o(tok_o),
    .lp_o(lp_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic set_evt(input int e[NCH]);
    for (int i = 0; i < NCH; i++) evt_cnt_i[i*CW +: CW] = CW'(e[i]);
  endtask

  // Steps one run cycle; k = cycles after the start edge, sampled at negedges.
  task automatic run_cycle(input int e[NCH], input bit issue, input int chg_at, input string tag);
    int base[NCH];
    int t_last;
    int acc;
    acc = A + C + 1;
    for (int i = 0; i < NCH; i++) begin
      base[i] = acc;
      acc = acc + e[i] + 1;
    end
    t_last = acc - 1;
    if (issue) begin
      set_evt(e);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    for (int k = 0; k <= t_last + 3; k++) begin
      logic [NCH-1:0] oe_e, tok_e, lp_e;
      logic [DW-1:0]  dat_e;
      oe_e = '0; tok_e = '0; lp_e = '0; dat_e = '0;
      if (k == chg_at) begin
        for (int i = 0; i < NCH; i++) evt_cnt_i[i*CW +: CW] = CW'(e[i] + 5);
      end
      for (int i = 0; i < NCH; i++) begin
        if (k >= base[i] && k < base[i] + e[i]) begin
          oe_e[i] = 1'b1;
          dat_e   = DW'((i << CW) | (k - base[i]));
        end
        if (k == base[i] + e[i]) tok_e[i] = 1'b1;
        lp_e[i] = !(k < A + C || oe_e[i] || tok_e[i]);
      end
      if (k < A + C + 1)
        chk(bus_oe_o == '0, {tag, " R1 bus quiet before readout"}, int'(bus_oe_o), 0);
      chk(bus_oe_o == oe_e, {tag, " R3 oe order"}, int'(bus_oe_o), int'(oe_e));
      chk(bus_data_o == dat_e, {tag, " R3/R2 bus word"}, int'(bus_data_o), int'(dat_e));
      chk(tok_o == tok_e, {tag, " R4/R5 token"}, int'(tok_o), int'(tok_e));
      chk(lp_o == lp_e, {tag, " R7 low-power"}, int'(lp_o), int'(lp_e));
      chk(done_o == (k > t_last), {tag, " R8 done"}, int'(done_o), int'(k > t_last));
      @(negedge clk);
    end
    set_evt(e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; evt_cnt_i = '0;
    repeat (3) @(negedge clk);
    chk(bus_oe_o == '0 && tok_o == '0, "R10 reset oe/tok", int'({bus_oe_o, tok_o}), 0);
    chk(done_o == 1'b0 && bus_data_o == '0, "R10 reset done/data", int'({done_o, bus_data_o}), 0);
    chk(lp_o == '1, "R10 reset low-power", int'(lp_o), 'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lp_o == '1 && bus_oe_o == '0, "R10 after release", int'(lp_o), 'hF);
  endtask

  task automatic t_mixed();
    int e[NCH] = '{2, 0, 3, 1};
    run_cycle(e, 1'b1, -1, "mixed R1");
  endtask

  task automatic t_all_zero();
    int e[NCH] = '{0, 0, 0, 0};
    run_cycle(e, 1'b1, -1, "zero R5");
  endtask

  task automatic t_full();
    int e[NCH] = '{15, 1, 15, 0};
    run_cycle(e, 1'b1, -1, "full R3");
  endtask

  task automatic t_late_change();
    int e[NCH] = '{1, 2, 0, 3};
    run_cycle(e, 1'b1, A + 1, "latch R6");
  endtask

  task automatic t_abort();
    int e1[NCH] = '{3, 3, 3, 3};
    int e2[NCH] = '{0, 2, 1, 0};
    set_evt(e1);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int k = 0; k < A + C + 2; k++) @(negedge clk);
    chk(bus_oe_o == 4'b0001, "R9 sending before abort", int'(bus_oe_o), 1);
    chk(bus_data_o == DW'(1), "R9 word before abort", int'(bus_data_o), 1);
    set_evt(e2);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(bus_oe_o == '0 && tok_o == '0, "R9 abort drops bus", int'({bus_oe_o, tok_o}), 0);
    run_cycle(e2, 1'b0, -1, "abort R9");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; reported = 1'b0;
    t_reset();
    t_mixed();
    t_all_zero();
    t_full();
    t_late_change();
    t_abort();
    t_mixed();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

endmodule